// File: doc/BRIEF.md
# Software-Driven I2C Waveform Decoder

This block turns an I2C waveform that software produces by toggling two general-purpose outputs into byte-level actions on a simple internal target port. Each time software updates the outputs, the new data and clock levels arrive together with a one-cycle `sampleValid` strobe. The block compares each sample with the levels it recorded from the previous sample. It recognises start and stop conditions and falling clock edges, and it walks an explicit per-bit sequence for the address byte, for written bytes and for read bytes.

On the target side the block issues single-cycle strobes for five actions: begin a transfer (with an address and a direction), deliver a written byte, fetch a byte to be read, report a not-acknowledge, and close the transfer. It also drives the level that software reads back on its data input. That level is the current bit of a byte being read, and low at all other times. Only the controller-side waveform is followed. Clock stretching, arbitration and open-drain electrical behaviour are not modelled.

Top module: `gpio_i2c_decoder`

## Requirements
- R1: After reset the block is idle, `sdaReadback` is 0, no strobe is asserted, and the recorded previous levels are both 1. As a result, a first sample with data 0 and clock 1 is already a start.
- R2: In idle, a sample where data falls from 1 to 0 while clock is 1 is a start condition, and the block enters an initializing state.
- R3: In the initializing state, a sample with a falling clock edge and data 0 enters the first (MSB) bit of a byte. Any other valid sample returns the block to idle with no strobe.
- R4: While a byte is being written, each falling clock edge shifts the data level into the byte, MSB first. On the ninth falling edge of the first byte after a start, `tgtStart` pulses. At that pulse, `tgtAddr` equals the byte with bit 0 cleared and `tgtRead` equals bit 0 of the byte.
- R5: On the ninth falling edge of each later byte in a write transfer, `tgtSend` pulses with `tgtWrData` equal to that byte. Writing then continues with the next byte's MSB.
- R6: If the captured address has bit 0 set, `tgtFetch` pulses in the same cycle as `tgtStart`, and the byte on `rdData` is loaded. While a byte is being read, `sdaReadback` is the MSB of the loaded byte. Each falling clock edge moves the next lower bit to `sdaReadback`.
- R7: On the falling clock edge after the eighth read bit (the controller acknowledge), data 0 pulses `tgtFetch` and loads a new byte from `rdData`. Data 1 pulses `tgtNack` and loads nothing. In both cases reading resumes at the MSB.
- R8: `sdaReadback` is 0 in every state other than reading a byte, including the two acknowledge states.
- R9: In any active state, data rising from 0 to 1 while clock is 1 is a stop. It pulses `tgtEnd` only if an address has been captured since the last start. The block then returns to idle.
- R10: Every target strobe lasts one cycle and appears only in a cycle where `sampleValid` is 1.
- R11: Cycles with `sampleValid` at 0 are ignored. Line levels in those cycles change neither the state nor the recorded previous levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Marks a cycle that carries a new line sample |
| sdaIn | input | 1 | Sampled data line level |
| sclIn | input | 1 | Sampled clock line level |
| rdData | input | BYTE_W | Byte from the target, valid in the cycle of `tgtFetch` |
| sdaReadback | output | 1 | Data level returned to software |
| tgtStart | output | 1 | Begin-transfer strobe |
| tgtAddr | output | BYTE_W | Target address with bit 0 cleared, valid with `tgtStart` |
| tgtRead | output | 1 | Direction flag (1 = read), valid with `tgtStart` |
| tgtSend | output | 1 | Written-byte strobe |
| tgtWrData | output | BYTE_W | Written byte, valid with `tgtSend` |
| tgtFetch | output | 1 | Fetch-byte strobe |
| tgtNack | output | 1 | Not-acknowledge strobe |
| tgtEnd | output | 1 | End-of-transfer strobe |

## Verification
The assertions take for granted that `sampleValid` marks the only cycles whose line levels carry meaning, and that `rdData` is valid in the cycle of a fetch. The assertions do not require the lines to be stable between samples. The bench keeps `rdData` fixed across each fetch cycle. In every non-sample cycle it drives the inverse of the sampled levels, so ignored cycles carry edges that would be decoded if they leaked through. The bench changes data only while clock is low, except where a start or stop is intended.

// File: rtl/gpio_i2c_pkg.sv
package gpio_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SEND,
    ST_ACKW,
    ST_RECV,
    ST_CACK
  } busState_e;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadRd;
    logic captureAddr;
    logic clearAddr;
  } dpCtl_t;

endpackage

// File: rtl/gpio_i2c_dp.sv
module gpio_i2c_dp
  import gpio_i2c_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              sdaIn,
  input  logic              sclIn,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] rdData,
  output logic              prevSda,
  output logic              prevScl,
  output logic [BYTE_W-1:0] buffer,
  output logic              addrValid,
  output logic              addrRead
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSda   <= 1'b1;
      prevScl   <= 1'b1;
      buffer    <= '0;
      addrValid <= 1'b0;
      addrRead  <= 1'b0;
    end else begin
      if (sampleValid) begin
        prevSda <= sdaIn;
        prevScl <= sclIn;
      end
      if (ctl.loadRd)
        buffer <= rdData;
      else if (ctl.shiftIn)
        buffer <= {buffer[BYTE_W-2:0], sdaIn};
      else if (ctl.shiftOut)
        buffer <= {buffer[BYTE_W-2:0], 1'b0};
      if (ctl.clearAddr) begin
        addrValid <= 1'b0;
        addrRead  <= 1'b0;
      end else if (ctl.captureAddr) begin
        addrValid <= 1'b1;
        addrRead  <= buffer[0];
      end
    end
  end

  // R11: ignored cycles leave the recorded line levels untouched
  p_prev_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(prevSda) && $stable(prevScl)));

  // R6: a fetch loads exactly the byte presented in that cycle
  p_fetch_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadRd |=> (buffer == $past(rdData)));

endmodule

// File: rtl/gpio_i2c_ctrl.sv
module gpio_i2c_ctrl
  import gpio_i2c_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleValid,
  input  logic      sdaIn,
  input  logic      sclIn,
  input  logic      prevSda,
  input  logic      prevScl,
  input  logic      addrValid,
  input  logic      addrRead,
  input  logic      bufLsb,
  output dpCtl_t    ctl,
  output logic      inRecv,
  output logic      stStart,
  output logic      stSend,
  output logic      stFetch,
  output logic      stNack,
  output logic      stEnd
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  busState_e        state, nextState;
  logic [CNT_W-1:0] bitCnt, nextCnt;
  logic             fallClk, startCond, stopCond, lastBit, readDir, goStop;

  assign fallClk   = sampleValid & prevScl & ~sclIn;
  assign startCond = sampleValid & prevSda & ~sdaIn & sclIn;
  assign stopCond  = sampleValid & ~prevSda & sdaIn & sclIn;
  assign lastBit   = (bitCnt == LAST_BIT);
  assign readDir   = addrValid ? addrRead : bufLsb;
  assign inRecv    = (state == ST_RECV);

  always_comb begin
    nextState = state;
    nextCnt   = bitCnt;
    ctl       = '0;
    stStart   = 1'b0;
    stSend    = 1'b0;
    stFetch   = 1'b0;
    stNack    = 1'b0;
    stEnd     = 1'b0;
    goStop    = 1'b0;
    unique case (state)
      ST_IDLE: if (startCond) nextState = ST_INIT;
      ST_INIT: if (sampleValid) begin
        if (fallClk && !sdaIn) begin
          nextState = ST_SEND;
          nextCnt   = '0;
        end else goStop = 1'b1;
      end
      ST_SEND: if (fallClk) begin
        ctl.shiftIn = 1'b1;
        if (lastBit) nextState = ST_ACKW;
        else nextCnt = bitCnt + 1'b1;
      end else if (stopCond) goStop = 1'b1;
      ST_ACKW: if (fallClk) begin
        if (!addrValid) begin
          stStart         = 1'b1;
          ctl.captureAddr = 1'b1;
        end else stSend = 1'b1;
        nextCnt = '0;
        if (readDir) begin
          stFetch    = 1'b1;
          ctl.loadRd = 1'b1;
          nextState  = ST_RECV;
        end else nextState = ST_SEND;
      end else if (stopCond) goStop = 1'b1;
      ST_RECV: if (fallClk) begin
        ctl.shiftOut = 1'b1;
        if (lastBit) nextState = ST_CACK;
        else nextCnt = bitCnt + 1'b1;
      end else if (stopCond) goStop = 1'b1;
      ST_CACK: if (fallClk) begin
        nextState = ST_RECV;
        nextCnt   = '0;
        if (!sdaIn) begin
          stFetch    = 1'b1;
          ctl.loadRd = 1'b1;
        end else stNack = 1'b1;
      end else if (stopCond) goStop = 1'b1;
      default: nextState = ST_IDLE;
    endcase
    if (goStop) begin
      nextState     = ST_IDLE;
      ctl.clearAddr = 1'b1;
      stEnd         = addrValid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= nextState;
      bitCnt <= nextCnt;
    end
  end

  // R11: no progress without a sample
  p_hold_state_r11: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(state) && $stable(bitCnt)));

  // R7: an acknowledge resolves to either a fetch or a nack, never both
  p_ack_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(stNack && stFetch));

  // R5: a byte is either the address or data, never both
  p_start_send_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(stStart && stSend));

  // R9: the end strobe always lands the block in idle
  p_end_to_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    stEnd |=> (state == ST_IDLE));

endmodule

// File: rtl/gpio_i2c_decoder.sv
module gpio_i2c_decoder
  import gpio_i2c_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              sdaIn,
  input  logic              sclIn,
  input  logic [BYTE_W-1:0] rdData,
  output logic              sdaReadback,
  output logic              tgtStart,
  output logic [BYTE_W-1:0] tgtAddr,
  output logic              tgtRead,
  output logic              tgtSend,
  output logic [BYTE_W-1:0] tgtWrData,
  output logic              tgtFetch,
  output logic              tgtNack,
  output logic              tgtEnd
);

  dpCtl_t            ctl;
  logic              prevSda, prevScl, addrValid, addrRead, inRecv;
  logic [BYTE_W-1:0] buffer;

  gpio_i2c_dp #(.BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sdaIn(sdaIn), .sclIn(sclIn), .ctl(ctl), .rdData(rdData),
    .prevSda(prevSda), .prevScl(prevScl), .buffer(buffer),
    .addrValid(addrValid), .addrRead(addrRead)
  );

  gpio_i2c_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sdaIn(sdaIn), .sclIn(sclIn), .prevSda(prevSda), .prevScl(prevScl),
    .addrValid(addrValid), .addrRead(addrRead), .bufLsb(buffer[0]),
    .ctl(ctl), .inRecv(inRecv),
    .stStart(tgtStart), .stSend(tgtSend), .stFetch(tgtFetch),
    .stNack(tgtNack), .stEnd(tgtEnd)
  );

  assign sdaReadback = inRecv & buffer[BYTE_W-1];
  assign tgtAddr     = {buffer[BYTE_W-1:1], 1'b0};
  assign tgtRead     = buffer[0];
  assign tgtWrData   = buffer;

  // R10: strobes only in sample cycles, and never two cycles running
  p_strobe_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    (tgtStart | tgtSend | tgtFetch | tgtNack | tgtEnd) |-> sampleValid);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    (tgtStart | tgtSend | tgtFetch | tgtNack | tgtEnd) |=>
      !(tgtStart | tgtSend | tgtFetch | tgtNack | tgtEnd));

endmodule

// File: tb/gpio_i2c_decoder_tb_top.sv
`timescale 1ns/1ps
module gpio_i2c_decoder_tb_top;

  localparam int K_START = 0, K_SEND = 1, K_FETCH = 2, K_NACK = 3, K_END = 4;

  typedef struct {
    int         kind;
    logic [7:0] data;
    string      req;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN, sampleValid, sdaIn, sclIn;
  logic [7:0] rdData;
  logic       sdaReadback, tgtStart, tgtRead, tgtSend, tgtFetch, tgtNack, tgtEnd;
  logic [7:0] tgtAddr, tgtWrData;

  expItem_t q[$];
  int       checks = 0;
  int       errors = 0;
  bit       done = 1'b0;

  always #2 clk = ~clk;

  gpio_i2c_decoder dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sdaIn(sdaIn),
    .sclIn(sclIn), .rdData(rdData), .sdaReadback(sdaReadback),
    .tgtStart(tgtStart), .tgtAddr(tgtAddr), .tgtRead(tgtRead),
    .tgtSend(tgtSend), .tgtWrData(tgtWrData), .tgtFetch(tgtFetch),
    .tgtNack(tgtNack), .tgtEnd(tgtEnd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expPush(input int kind, input logic [7:0] data, input string req);
    expItem_t e;
    e.kind = kind; e.data = data; e.req = req;
    q.push_back(e);
  endtask

  task automatic cmpOne(input int kind, input logic [7:0] d);
    expItem_t e;
    if (q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R10 unexpected strobe kind %0d: actual 1 expected 0", kind);
    end else begin
      e = q.pop_front();
      chk(e.kind == kind && e.data == d, e.req, "strobe kind/data",
          kind * 256 + int'(d), e.kind * 256 + int'(e.data));
    end
  endtask

  // monitor: samples between a driving negedge and the next posedge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN) begin
        if (tgtStart) cmpOne(K_START, {tgtAddr[7:1], tgtRead});
        if (tgtSend)  cmpOne(K_SEND, tgtWrData);
        if (tgtFetch) cmpOne(K_FETCH, 8'h00);
        if (tgtNack)  cmpOne(K_NACK, 8'h00);
        if (tgtEnd)   cmpOne(K_END, 8'h00);
      end
    end
  end

  // one sample, then one ignored cycle carrying inverted levels (R11)
  task automatic smp(input logic d, input logic c);
    @(negedge clk);
    sdaIn = d; sclIn = c; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0; sdaIn = ~d; sclIn = ~c;
  endtask

  task automatic bitOut(input logic b);
    smp(b, 1'b0); smp(b, 1'b1); smp(b, 1'b0);
  endtask

  task automatic byteOut(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bitOut(v[i]);
    #1 chk(sdaReadback == 1'b0, "R8", "readback in ack wait", sdaReadback, 0);
  endtask

  task automatic ackClk(input logic lvl);
    smp(lvl, 1'b0); smp(lvl, 1'b1); smp(lvl, 1'b0);
  endtask

  task automatic startSeq();
    smp(1'b1, 1'b1); smp(1'b0, 1'b1); smp(1'b0, 1'b0);
  endtask

  task automatic stopSeq();
    smp(1'b0, 1'b0); smp(1'b0, 1'b1); smp(1'b1, 1'b1);
  endtask

  task automatic readByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      smp(1'b1, 1'b0);
      smp(1'b1, 1'b1);
      #1 chk(sdaReadback == v[i], "R6", "read bit", sdaReadback, v[i]);
      smp(1'b1, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sampleValid = 1'b0; sdaIn = 1'b1; sclIn = 1'b1; rdData = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1 chk(sdaReadback == 1'b0, "R1", "readback after reset", sdaReadback, 0);

    // write transfer; start straight from reset levels (R1, R2, R4, R5, R9)
    smp(1'b0, 1'b1);
    smp(1'b0, 1'b0);
    byteOut(8'h34);
    expPush(K_START, 8'h34, "R4");
    ackClk(1'b0);
    byteOut(8'hA5);
    expPush(K_SEND, 8'hA5, "R5");
    ackClk(1'b1);
    byteOut(8'h0F);
    expPush(K_SEND, 8'h0F, "R5");
    ackClk(1'b0);
    expPush(K_END, 8'h00, "R9");
    stopSeq();

    // read transfer with ack then nack (R6, R7, R8)
    startSeq();
    byteOut(8'h35);
    rdData = 8'hC6;
    expPush(K_START, 8'h35, "R6");
    expPush(K_FETCH, 8'h00, "R6");
    ackClk(1'b1);
    readByte(8'hC6);
    #1 chk(sdaReadback == 1'b0, "R8", "readback in controller ack", sdaReadback, 0);
    rdData = 8'h5B;
    expPush(K_FETCH, 8'h00, "R7");
    ackClk(1'b0);
    readByte(8'h5B);
    rdData = 8'hFF;
    expPush(K_NACK, 8'h00, "R7");
    ackClk(1'b1);
    #1 chk(sdaReadback == 1'b0, "R7", "readback after nack (no load)", sdaReadback, 0);
    expPush(K_END, 8'h00, "R9");
    stopSeq();

    // stop before any address captured: no end strobe (R9)
    startSeq();
    bitOut(1'b1);
    bitOut(1'b0);
    stopSeq();
    #1 chk(q.size() == 0, "R9", "no end without address", q.size(), 0);

    // initializing state aborted by a non-matching sample (R3)
    smp(1'b1, 1'b1);
    smp(1'b0, 1'b1);
    smp(1'b0, 1'b1);
    for (int i = 0; i < 9; i++) bitOut(1'b0);
    #1 chk(sdaReadback == 1'b0, "R3", "readback after abort", sdaReadback, 0);

    // recovery: a fresh write transfer is decoded normally (R3, R11)
    startSeq();
    byteOut(8'h50);
    expPush(K_START, 8'h50, "R11");
    ackClk(1'b0);
    expPush(K_END, 8'h00, "R9");
    stopSeq();

    repeat (4) @(negedge clk);
    #1 chk(q.size() == 0, "R10", "pending expected strobes", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule